// File: doc/BRIEF.md
# Nested Translation IOTLB with Stage-Attributed Permission Faults

This block is a small, fully associative translation cache for a two-stage address translation unit. A fill port accepts the result of a stage-1 walk together with the matching stage-2 walk and folds them into one combined entry. The folded entry maps an input address directly to a final output address. The fold keeps whichever of the two pages is finer, and it carries both permission sets. A fill can also be marked single-stage. In that case only the stage-1 fields are used, and the stage-2 fields are ignored.

A lookup port takes an input address and an access type, read or write. One cycle after the request is accepted, it returns a hit with the translated address, a miss, or a permission fault. Each entry keeps the stage-1 and stage-2 permissions apart. Because of that, a fault raised from a cached entry can still name the stage that denied the access.

Top module: `nested_iotlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid`, `rsp_hit` and `rsp_fault` are low, and every lookup misses.
- R2: `fill_ready` and `lkp_ready` are always high. `rsp_valid` is high in exactly the cycle after an accepted lookup and low otherwise.
- R3: A lookup matches an entry when (address AND NOT entry mask) equals the entry base. When no valid entry matches, the response shows hit, fault and address all zero. If several entries match, the lowest slot index wins.
- R4: On a two-stage fill, the entry takes the stage-2 mask, granule and level when the stage-2 mask is numerically smaller. Otherwise, ties included, it takes the stage-1 values.
- R5: The entry base is the fill input address AND NOT the chosen mask. The stored output is (stage-2 output AND NOT stage-2 mask) OR (stage-1 output AND stage-2 mask). A hit returns (stored output AND NOT entry mask) OR (lookup address AND entry mask).
- R6: On a single-stage fill (`fill_nested`=0), the mask, granule, level and output come from stage 1. The stage-2 permission is set equal to the stage-1 permission, and every stage-2 input is ignored.
- R7: Permissions are 2 bits wide: bit 0 grants read and bit 1 grants write. An access is granted only if the requested bit is set in both the stage-1 and the stage-2 permission of the matched entry.
- R8: A denied access on a match gives `rsp_fault`=1 and `rsp_hit`=0, with the address, granule and level all zero.
- R9: A fault names stage 1 (`rsp_fault_s2`=0) if the stage-1 permission lacks the requested bit. Otherwise it names stage 2 (`rsp_fault_s2`=1).
- R10: A fill writes the lowest-index invalid slot. When all slots are valid, it overwrites the slot under a round-robin pointer. The pointer starts at 0 and advances by one, with wrap, on each such overwrite.
- R11: A lookup accepted in the same cycle as a fill sees the table as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill accepted (always high) |
| fill_nested | input | 1 | 1: merge both stages, 0: stage 1 only |
| fill_iaddr | input | AW | Input address that was walked |
| fill_s1_mask | input | AW | Stage-1 page offset mask |
| fill_s1_oaddr | input | AW | Stage-1 output (intermediate) address |
| fill_s1_gran | input | GW | Stage-1 granule code |
| fill_s1_level | input | LW | Stage-1 walk level |
| fill_s1_perm | input | 2 | Stage-1 permission {write, read} |
| fill_s2_mask | input | AW | Stage-2 page offset mask |
| fill_s2_oaddr | input | AW | Stage-2 output address |
| fill_s2_gran | input | GW | Stage-2 granule code |
| fill_s2_level | input | LW | Stage-2 walk level |
| fill_s2_perm | input | 2 | Stage-2 permission {write, read} |
| lkp_valid | input | 1 | Lookup request |
| lkp_ready | output | 1 | Lookup accepted (always high) |
| lkp_addr | input | AW | Lookup input address |
| lkp_write | input | 1 | 1: write access, 0: read access |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | Permission fault on a matching entry |
| rsp_fault_s2 | output | 1 | Fault blamed on stage 2 |
| rsp_oaddr | output | AW | Translated address on a hit |
| rsp_gran | output | GW | Granule of the hit entry |
| rsp_level | output | LW | Level of the hit entry |

## Verification
The hardest cases to reach are the two fault attributions on a cached entry. Each needs an entry whose two permission sets disagree, and the stage-2 set is never visible at the ports. The stimulus first fills entries where only stage 2 lacks write, entries where only stage 1 lacks write, and a single-stage entry whose ignored stage-2 inputs would deny the access if they were used. Read and write lookups then land on the same pages. Round-robin overwrite and a fill racing a lookup are reached by filling past capacity and by driving a fill and a lookup of the same address on one edge.

// File: rtl/ntlb_pkg.sv
package ntlb_pkg;
   localparam int PERM_W  = 2;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;

   typedef enum logic {
      BLAME_S1 = 1'b0,
      BLAME_S2 = 1'b1
   } blame_e;
endpackage

// File: rtl/ntlb_merge.sv
module ntlb_merge #(
   parameter int AW = 32,
   parameter int GW = 2,
   parameter int LW = 2
) (
   input  logic                       nested,
   input  logic [AW-1:0]              iaddr,
   input  logic [AW-1:0]              s1_mask,
   input  logic [AW-1:0]              s1_oaddr,
   input  logic [GW-1:0]              s1_gran,
   input  logic [LW-1:0]              s1_level,
   input  logic [ntlb_pkg::PERM_W-1:0] s1_perm,
   input  logic [AW-1:0]              s2_mask,
   input  logic [AW-1:0]              s2_oaddr,
   input  logic [GW-1:0]              s2_gran,
   input  logic [LW-1:0]              s2_level,
   input  logic [ntlb_pkg::PERM_W-1:0] s2_perm,
   output logic [AW-1:0]              m_base,
   output logic [AW-1:0]              m_mask,
   output logic [AW-1:0]              m_out,
   output logic [GW-1:0]              m_gran,
   output logic [LW-1:0]              m_level,
   output logic [ntlb_pkg::PERM_W-1:0] m_perm,
   output logic [ntlb_pkg::PERM_W-1:0] m_pperm
);
   logic take_s2;

   // finer page wins; equal sizes keep stage 1
   assign take_s2 = nested && (s2_mask < s1_mask);

   always_comb begin
      m_mask  = take_s2 ? s2_mask  : s1_mask;
      m_gran  = take_s2 ? s2_gran  : s1_gran;
      m_level = take_s2 ? s2_level : s1_level;
      m_base  = iaddr & ~m_mask;
      m_perm  = s1_perm;
      if (nested) begin
         m_out   = (s2_oaddr & ~s2_mask) | (s1_oaddr & s2_mask);
         m_pperm = s2_perm;
      end else begin
         m_out   = s1_oaddr;
         m_pperm = s1_perm;
      end
   end
endmodule

// File: rtl/ntlb_victim.sv
module ntlb_victim #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [N-1:0]  valid_vec,
   output logic [IW-1:0] victim,
   output logic          full
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] ptr_nxt;

   assign full = &valid_vec;

   generate
      if (N == (1 << IW)) begin : g_pow2
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap
         assign ptr_nxt = (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_comb begin
      victim = ptr_q;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) victim = IW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ptr_q <= '0;
      else if (adv && full)  ptr_q <= ptr_nxt;
   end

   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && full) |=> (ptr_q != $past(ptr_q))); // R10
endmodule

// File: rtl/ntlb_lookup.sv
module ntlb_lookup #(
   parameter int N  = 4,
   parameter int AW = 32,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [AW-1:0] addr,
   input  logic [N-1:0]  valid_vec,
   input  logic [AW-1:0] base_a [N],
   input  logic [AW-1:0] mask_a [N],
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N-1:0] hitv;

   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign hitv[g] = valid_vec[g] && ((addr & ~mask_a[g]) == base_a[g]);
      end
   endgenerate

   assign any = |hitv;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hitv[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/nested_iotlb.sv
module nested_iotlb #(
   parameter int AW      = 32,
   parameter int ENTRIES = 4,
   parameter int GW      = 2,
   parameter int LW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_valid,
   output logic          fill_ready,
   input  logic          fill_nested,
   input  logic [AW-1:0] fill_iaddr,
   input  logic [AW-1:0] fill_s1_mask,
   input  logic [AW-1:0] fill_s1_oaddr,
   input  logic [GW-1:0] fill_s1_gran,
   input  logic [LW-1:0] fill_s1_level,
   input  logic [1:0]    fill_s1_perm,
   input  logic [AW-1:0] fill_s2_mask,
   input  logic [AW-1:0] fill_s2_oaddr,
   input  logic [GW-1:0] fill_s2_gran,
   input  logic [LW-1:0] fill_s2_level,
   input  logic [1:0]    fill_s2_perm,
   input  logic          lkp_valid,
   output logic          lkp_ready,
   input  logic [AW-1:0] lkp_addr,
   input  logic          lkp_write,
   output logic          rsp_valid,
   output logic          rsp_hit,
   output logic          rsp_fault,
   output logic          rsp_fault_s2,
   output logic [AW-1:0] rsp_oaddr,
   output logic [GW-1:0] rsp_gran,
   output logic [LW-1:0] rsp_level
);
   import ntlb_pkg::*;

   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("nested_iotlb: ENTRIES must be at least 2");
      end
      if (AW < 12) begin : g_bad_aw
         $error("nested_iotlb: AW must be at least 12");
      end
      if (GW < 1 || LW < 1) begin : g_bad_fields
         $error("nested_iotlb: GW and LW must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] e_valid;
   logic [AW-1:0]      e_base  [ENTRIES];
   logic [AW-1:0]      e_mask  [ENTRIES];
   logic [AW-1:0]      e_out   [ENTRIES];
   logic [GW-1:0]      e_gran  [ENTRIES];
   logic [LW-1:0]      e_level [ENTRIES];
   logic [PERM_W-1:0]  e_perm  [ENTRIES];
   logic [PERM_W-1:0]  e_pperm [ENTRIES];

   logic [AW-1:0]     m_base, m_mask, m_out;
   logic [GW-1:0]     m_gran;
   logic [LW-1:0]     m_level;
   logic [PERM_W-1:0] m_perm, m_pperm;
   logic [IW-1:0]     victim;
   logic              full;
   logic              fill_fire;
   logic              l_any;
   logic [IW-1:0]     l_idx;

   assign fill_ready = 1'b1;
   assign lkp_ready  = 1'b1;
   assign fill_fire  = fill_valid && fill_ready;

   ntlb_merge #(.AW(AW), .GW(GW), .LW(LW)) u_merge (
      .nested(fill_nested), .iaddr(fill_iaddr),
      .s1_mask(fill_s1_mask), .s1_oaddr(fill_s1_oaddr), .s1_gran(fill_s1_gran),
      .s1_level(fill_s1_level), .s1_perm(fill_s1_perm),
      .s2_mask(fill_s2_mask), .s2_oaddr(fill_s2_oaddr), .s2_gran(fill_s2_gran),
      .s2_level(fill_s2_level), .s2_perm(fill_s2_perm),
      .m_base(m_base), .m_mask(m_mask), .m_out(m_out), .m_gran(m_gran),
      .m_level(m_level), .m_perm(m_perm), .m_pperm(m_pperm)
   );

   ntlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
      .clk(clk), .rst_n(rst_n), .adv(fill_fire), .valid_vec(e_valid),
      .victim(victim), .full(full)
   );

   ntlb_lookup #(.N(ENTRIES), .AW(AW), .IW(IW)) u_lookup (
      .addr(lkp_addr), .valid_vec(e_valid), .base_a(e_base), .mask_a(e_mask),
      .any(l_any), .idx(l_idx)
   );

   // table storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            e_base[i]  <= '0;
            e_mask[i]  <= '0;
            e_out[i]   <= '0;
            e_gran[i]  <= '0;
            e_level[i] <= '0;
            e_perm[i]  <= '0;
            e_pperm[i] <= '0;
         end
      end else if (fill_fire) begin
         e_valid[victim] <= 1'b1;
         e_base[victim]  <= m_base;
         e_mask[victim]  <= m_mask;
         e_out[victim]   <= m_out;
         e_gran[victim]  <= m_gran;
         e_level[victim] <= m_level;
         e_perm[victim]  <= m_perm;
         e_pperm[victim] <= m_pperm;
      end
   end

   // permission check on the matched entry
   int     rbit;
   logic   s1_ok, s2_ok, grant;
   blame_e blame;
   logic [AW-1:0] x_addr;

   always_comb begin
      rbit   = lkp_write ? PERM_WR : PERM_RD;
      s1_ok  = e_perm[l_idx][rbit];
      s2_ok  = e_pperm[l_idx][rbit];
      grant  = s1_ok && s2_ok;
      blame  = s1_ok ? BLAME_S2 : BLAME_S1;
      x_addr = (e_out[l_idx] & ~e_mask[l_idx]) | (lkp_addr & e_mask[l_idx]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_fault_s2 <= 1'b0;
         rsp_oaddr    <= '0;
         rsp_gran     <= '0;
         rsp_level    <= '0;
      end else begin
         rsp_valid    <= lkp_valid;
         rsp_hit      <= lkp_valid && l_any && grant;
         rsp_fault    <= lkp_valid && l_any && !grant;
         rsp_fault_s2 <= lkp_valid && l_any && !grant && (blame == BLAME_S2);
         rsp_oaddr    <= (lkp_valid && l_any && grant) ? x_addr : '0;
         rsp_gran     <= (lkp_valid && l_any && grant) ? e_gran[l_idx] : '0;
         rsp_level    <= (lkp_valid && l_any && grant) ? e_level[l_idx] : '0;
      end
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_valid |=> rsp_valid); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> !rsp_valid); // R2
   AST_FAULT_HIDES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (!rsp_hit && rsp_oaddr == '0)); // R8
   AST_BLAME_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault_s2 |-> rsp_fault); // R9
   AST_FINER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_nested) |-> (m_mask <= fill_s1_mask && m_mask <= fill_s2_mask)); // R4
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> ((m_base & m_mask) == '0)); // R5
endmodule

// File: tb/tb_nested_iotlb.sv
`timescale 1ns/1ps
module tb_nested_iotlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_valid = 1'b0, fill_nested = 1'b0;
   logic        fill_ready, lkp_ready;
   logic [31:0] fill_iaddr = '0, fill_s1_mask = '0, fill_s1_oaddr = '0;
   logic [31:0] fill_s2_mask = '0, fill_s2_oaddr = '0;
   logic [1:0]  fill_s1_gran = '0, fill_s1_level = '0, fill_s1_perm = '0;
   logic [1:0]  fill_s2_gran = '0, fill_s2_level = '0, fill_s2_perm = '0;
   logic        lkp_valid = 1'b0, lkp_write = 1'b0;
   logic [31:0] lkp_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_fault_s2;
   logic [31:0] rsp_oaddr;
   logic [1:0]  rsp_gran, rsp_level;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   nested_iotlb dut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_nested(fill_nested),
      .fill_iaddr(fill_iaddr), .fill_s1_mask(fill_s1_mask), .fill_s1_oaddr(fill_s1_oaddr),
      .fill_s1_gran(fill_s1_gran), .fill_s1_level(fill_s1_level), .fill_s1_perm(fill_s1_perm),
      .fill_s2_mask(fill_s2_mask), .fill_s2_oaddr(fill_s2_oaddr),
      .fill_s2_gran(fill_s2_gran), .fill_s2_level(fill_s2_level), .fill_s2_perm(fill_s2_perm),
      .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr), .lkp_write(lkp_write),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_fault_s2(rsp_fault_s2), .rsp_oaddr(rsp_oaddr),
      .rsp_gran(rsp_gran), .rsp_level(rsp_level)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        wr;
      logic        hit;
      logic        fault;
      logic        s2;
      logic [31:0] oa;
      logic [1:0]  gran;
      logic [1:0]  lvl;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_1ABC, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_5ABC, 2'd0, 2'd3, 8'd4}, // R4 R5 finer stage-2 page
      '{32'h0040_1ABC, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0,         2'd0, 2'd0, 8'd9}, // R9 stage 2 lacks write
      '{32'h0040_2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         2'd0, 2'd0, 8'd3}, // R3 outside finer page
      '{32'h0060_0FF0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h9000_0FF0, 2'd1, 2'd3, 8'd4}, // R4 finer stage-1 page
      '{32'h0060_0FF0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,         2'd0, 2'd0, 8'd9}, // R9 stage 1 lacks write
      '{32'h0070_0010, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA000_0010, 2'd1, 2'd2, 8'd4}, // R4 tie keeps stage 1
      '{32'h0070_0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA000_0010, 2'd1, 2'd2, 8'd7}, // R7 both grant write
      '{32'h0080_0444, 1'b1, 1'b1, 1'b0, 1'b0, 32'hB000_0444, 2'd2, 2'd1, 8'd6}, // R6 stage-2 inputs ignored
      '{32'h0080_0444, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'd0, 2'd0, 8'd6}, // R6 parent copies own perm
      '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         2'd0, 2'd0, 8'd3}  // R3 miss
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_rsp(input string tag, input logic h, input logic f, input logic s2,
                            input logic [31:0] oa, input logic [1:0] g, input logic [1:0] l);
      chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({tag, " hit"},   {31'd0, rsp_hit}, {31'd0, h});
      chk({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, f});
      chk({tag, " blame"}, {31'd0, rsp_fault_s2}, {31'd0, s2});
      chk({tag, " oaddr"}, rsp_oaddr, oa);
      chk({tag, " gran"},  {30'd0, rsp_gran}, {30'd0, g});
      chk({tag, " level"}, {30'd0, rsp_level}, {30'd0, l});
   endtask

   task automatic set_fill(input logic nst, input logic [31:0] ia,
                           input logic [31:0] m1, input logic [31:0] o1, input logic [1:0] g1,
                           input logic [1:0] l1, input logic [1:0] p1,
                           input logic [31:0] m2, input logic [31:0] o2, input logic [1:0] g2,
                           input logic [1:0] l2, input logic [1:0] p2);
      fill_valid = 1'b1; fill_nested = nst; fill_iaddr = ia;
      fill_s1_mask = m1; fill_s1_oaddr = o1; fill_s1_gran = g1; fill_s1_level = l1; fill_s1_perm = p1;
      fill_s2_mask = m2; fill_s2_oaddr = o2; fill_s2_gran = g2; fill_s2_level = l2; fill_s2_perm = p2;
   endtask

   task automatic lookup(input logic [31:0] a, input logic w);
      @(negedge clk);
      lkp_valid = 1'b1; lkp_addr = a; lkp_write = w;
      @(negedge clk);
      lkp_valid = 1'b0;
   endtask

   task automatic end_fill;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_hit after reset", {31'd0, rsp_hit}, 32'd0);
      chk("R2 fill_ready", {31'd0, fill_ready}, 32'd1);
      chk("R2 lkp_ready", {31'd0, lkp_ready}, 32'd1);
      lookup(32'h0040_1ABC, 1'b0);
      check_rsp("R1 empty table miss", 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
      @(negedge clk);
      chk("R2 no lookup no response", {31'd0, rsp_valid}, 32'd0);

      // slot 0: stage-2 page finer, stage 2 read only
      @(negedge clk);
      set_fill(1'b1, 32'h0040_1234, 32'h001F_FFFF, 32'h1000_1234, 2'd2, 2'd2, 2'b11,
               32'h0000_0FFF, 32'h8000_5000, 2'd0, 2'd3, 2'b01);
      // slot 1: stage-1 page finer, stage 1 read only
      @(negedge clk);
      set_fill(1'b1, 32'h0060_0000, 32'h0000_0FFF, 32'h2000_0000, 2'd1, 2'd3, 2'b01,
               32'h001F_FFFF, 32'h9000_0000, 2'd2, 2'd1, 2'b11);
      // slot 2: equal masks
      @(negedge clk);
      set_fill(1'b1, 32'h0070_0000, 32'h0000_0FFF, 32'h3000_0000, 2'd1, 2'd2, 2'b11,
               32'h0000_0FFF, 32'hA000_0000, 2'd3, 2'd1, 2'b11);
      // slot 3: single stage, write only, misleading stage-2 inputs
      @(negedge clk);
      set_fill(1'b0, 32'h0080_0000, 32'h0000_0FFF, 32'hB000_0000, 2'd2, 2'd1, 2'b10,
               32'h0000_000F, 32'hDEAD_0000, 2'd3, 2'd3, 2'b01);
      end_fill();

      for (int i = 0; i < NV; i++) begin
         lookup(VECS[i].addr, VECS[i].wr);
         check_rsp($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].hit, VECS[i].fault,
                   VECS[i].s2, VECS[i].oa, VECS[i].gran, VECS[i].lvl);
      end

      // R10: full table, round-robin overwrites slot 0
      @(negedge clk);
      set_fill(1'b1, 32'h0090_0000, 32'h0000_0FFF, 32'h0000_0000, 2'd0, 2'd3, 2'b11,
               32'h0000_0FFF, 32'hC000_0000, 2'd0, 2'd3, 2'b11);
      end_fill();
      lookup(32'h0040_1ABC, 1'b0);
      check_rsp("R10 slot 0 evicted", 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
      lookup(32'h0090_0008, 1'b0);
      check_rsp("R10 new entry hit", 1'b1, 1'b0, 1'b0, 32'hC000_0008, 2'd0, 2'd3);

      // R11: fill and lookup of the same address in one cycle
      @(negedge clk);
      set_fill(1'b1, 32'h00A0_0000, 32'h0000_0FFF, 32'h0000_0000, 2'd1, 2'd1, 2'b11,
               32'h0000_0FFF, 32'hD000_0000, 2'd1, 2'd1, 2'b11);
      lkp_valid = 1'b1; lkp_addr = 32'h00A0_0020; lkp_write = 1'b0;
      @(negedge clk);
      fill_valid = 1'b0; lkp_valid = 1'b0;
      check_rsp("R11 same-cycle lookup sees old table", 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
      lookup(32'h00A0_0020, 1'b0);
      check_rsp("R11 next lookup hits", 1'b1, 1'b0, 1'b0, 32'hD000_0020, 2'd1, 2'd1);
      lookup(32'h0060_0FF0, 1'b0);
      check_rsp("R10 pointer moved to slot 1", 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 2'd0);
      lookup(32'h0070_0010, 1'b0);
      check_rsp("R10 slot 2 kept", 1'b1, 1'b0, 1'b0, 32'hA000_0010, 2'd1, 2'd2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule